// File: doc/BRIEF.md
# NAND Invalid Block Scanner

This engine sits on the host side of a small-page NAND flash and builds a good/bad map of the whole device. When started, it visits the erase blocks in ascending order. For each block it points the device at the spare area of the block's first page and fetches one status byte from it. It then reports a verdict for that block. A block is reported invalid when its status byte holds two or more zero bits. It is not compared against a fixed marker value.

The engine reaches the flash through an abstract bus-cycle port. The port has three request lines: command, address and data read. A shared data-out byte goes with the requests, and a single done handshake completes each one. A ready/busy input tells the engine when the device has finished moving the page into its register.

Results leave the engine as a stream of one-cycle pulses, each carrying the block index and its verdict. A running count of invalid blocks is also available. A one-cycle done pulse marks the end of the scan.

Top module: `nand_badblk_scan`

## Requirements
- R1: A start pulse while idle begins a scan at block 0. Each block's access opens with a command request carrying 8'h50.
- R2: The command is followed by exactly three address requests, in this order. The first is the spare column 8'd5. The second is the low row byte, row[7:0]. The third is the high row byte, {3'b000, row[12:8]}. Here row = block * 16, the first page of the block.
- R3: After the third address, no data-read request is raised until at least WB_CYCLES cycles have passed and ready_i is high.
- R4: blk_bad_o is 1 (invalid) exactly when the status byte read for that block has two or more bits equal to 0. A byte with zero or one zero bits gives blk_bad_o = 0.
- R5: Blocks are reported in ascending order, 0 to 511, once each. blk_valid_o is a one-cycle pulse in the cycle after the data-read done.
- R6: bad_cnt_o is cleared when a start is accepted. After that it equals the number of invalid verdicts reported so far, and it holds its value after the scan.
- R7: done_o pulses for exactly one cycle, in the same cycle as the result for block 511. busy_o is low in the following cycle.
- R8: A start pulse while a scan is in progress is ignored. The scan continues without restarting and without clearing the count.
- R9: Out of reset the block is idle: busy_o, done_o, blk_valid_o and all request lines are 0, and bad_cnt_o is 0.
- R10: At most one request line is high at a time, and none is high while idle. A request stays high until bus_done_i completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| cmd_req_o | output | 1 | Command cycle request |
| addr_req_o | output | 1 | Address cycle request |
| rd_req_o | output | 1 | Data read cycle request |
| bus_data_o | output | 8 | Command or address byte for the current request |
| bus_done_i | input | 1 | Completes the pending request |
| bus_rdata_i | input | 8 | Read byte, valid with bus_done_i on a read |
| ready_i | input | 1 | Device ready (high) or busy (low) |
| blk_valid_o | output | 1 | Verdict pulse |
| blk_idx_o | output | 9 | Block index of the verdict |
| blk_bad_o | output | 1 | 1 = block invalid |
| bad_cnt_o | output | 10 | Invalid blocks counted in this scan |

## Verification
The bench feeds status bytes that sit on the boundary of the verdict: 8'hFE and 8'h7F have one zero bit, 8'hFC and 8'hEE have two. A design that compared against a marker, or that used the wrong threshold, would flip the verdicts on these bytes. The bench also holds ready low for a varying number of cycles and checks the address bytes of every block. A design that read before the device was ready, or that shifted the row field, would show a wrong byte or a read during busy. A second scan applies a start pulse partway through and marks blocks 0 and 511 invalid. A design that restarted on that pulse, cleared its count, missed the last block or raised done more than once would break the index sequence or the count.

// File: rtl/nand_scan_pkg.sv
package nand_scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_AD0, S_AD1, S_AD2, S_WAIT, S_READ, S_FIN
  } scan_st_e;
endpackage

// File: rtl/nand_zero_cnt.sv
module nand_zero_cnt #(
  parameter int W  = 8,
  parameter int ZW = $clog2(W + 1)
) (
  input  logic [W-1:0]  byte_i,
  output logic [ZW-1:0] zeros_o
);
  logic [W-1:0] inv;

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign inv[i] = ~byte_i[i];
  end

  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < W; i++) zeros_o = zeros_o + ZW'(inv[i]);
  end
endmodule

// File: rtl/nand_scan_seq.sv
module nand_scan_seq
  import nand_scan_pkg::*;
#(
  parameter int          NUM_BLOCKS = 512,
  parameter int          BLK_W      = 9,
  parameter int          PG_W       = 4,
  parameter logic [7:0]  STATUS_COL = 8'd5,
  parameter logic [7:0]  SPARE_CMD  = 8'h50,
  parameter int          WB_CYCLES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             bus_done_i,
  input  logic             ready_i,
  output logic             cmd_req_o,
  output logic             addr_req_o,
  output logic             rd_req_o,
  output logic [7:0]       bus_data_o,
  output logic             clear_o,
  output logic             sample_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int               WB_W = $clog2(WB_CYCLES + 1);
  localparam logic [BLK_W-1:0] LAST = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [WB_W-1:0]  WB_END = WB_W'(WB_CYCLES);

  scan_st_e         st_q, st_d;
  logic [BLK_W-1:0] blk_q;
  logic [WB_W-1:0]  wb_q;
  logic [15:0]      row16;

  // first page of the block: page bits are zero
  assign row16 = 16'(blk_q) << PG_W;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (start_i)    st_d = S_CMD;
      S_CMD:  if (bus_done_i) st_d = S_AD0;
      S_AD0:  if (bus_done_i) st_d = S_AD1;
      S_AD1:  if (bus_done_i) st_d = S_AD2;
      S_AD2:  if (bus_done_i) st_d = S_WAIT;
      S_WAIT: if (wb_q == WB_END && ready_i) st_d = S_READ;
      S_READ: if (bus_done_i) st_d = (blk_q == LAST) ? S_FIN : S_CMD;
      S_FIN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      blk_q <= '0;
      wb_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE)                  blk_q <= '0;
      else if (st_q == S_READ && bus_done_i) blk_q <= blk_q + 1'b1;
      if (st_q != S_WAIT)    wb_q <= '0;
      else if (wb_q != WB_END) wb_q <= wb_q + 1'b1;
    end
  end

  always_comb begin
    bus_data_o = 8'h00;
    unique case (st_q)
      S_CMD:   bus_data_o = SPARE_CMD;
      S_AD0:   bus_data_o = STATUS_COL;
      S_AD1:   bus_data_o = row16[7:0];
      S_AD2:   bus_data_o = row16[15:8];
      default: bus_data_o = 8'h00;
    endcase
  end

  assign cmd_req_o  = (st_q == S_CMD);
  assign addr_req_o = (st_q == S_AD0) || (st_q == S_AD1) || (st_q == S_AD2);
  assign rd_req_o   = (st_q == S_READ);
  assign clear_o    = (st_q == S_IDLE) && start_i;
  assign sample_o   = (st_q == S_READ) && bus_done_i;
  assign blk_o      = blk_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = (st_q == S_FIN);
endmodule

// File: rtl/nand_bad_tally.sv
module nand_bad_tally #(
  parameter int BLK_W   = 9,
  parameter int CNT_W   = 10,
  parameter int ZW      = 4,
  parameter int BAD_MIN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [ZW-1:0]    zeros_i,
  output logic             valid_o,
  output logic [BLK_W-1:0] idx_o,
  output logic             bad_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic is_bad;
  assign is_bad = (zeros_i >= ZW'(BAD_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      bad_o   <= 1'b0;
      cnt_o   <= '0;
    end else begin
      valid_o <= sample_i;
      if (sample_i) begin
        idx_o <= blk_i;
        bad_o <= is_bad;
      end
      if (clear_i)                cnt_o <= '0;
      else if (sample_i && is_bad) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/nand_badblk_scan.sv
module nand_badblk_scan #(
  parameter int         NUM_BLOCKS      = 512,
  parameter int         PAGES_PER_BLOCK = 16,
  parameter logic [7:0] STATUS_COL      = 8'd5,
  parameter logic [7:0] SPARE_CMD       = 8'h50,
  parameter int         WB_CYCLES       = 2,
  parameter int         BAD_MIN         = 2,
  parameter int         BLK_W           = $clog2(NUM_BLOCKS),
  parameter int         CNT_W           = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cmd_req_o,
  output logic             addr_req_o,
  output logic             rd_req_o,
  output logic [7:0]       bus_data_o,
  input  logic             bus_done_i,
  input  logic [7:0]       bus_rdata_i,
  input  logic             ready_i,
  output logic             blk_valid_o,
  output logic [BLK_W-1:0] blk_idx_o,
  output logic             blk_bad_o,
  output logic [CNT_W-1:0] bad_cnt_o
);
  localparam int PG_W = $clog2(PAGES_PER_BLOCK);
  localparam int ZW   = $clog2(9);

  logic             clear, sample;
  logic [BLK_W-1:0] blk;
  logic [ZW-1:0]    zeros;

  nand_scan_seq #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .PG_W(PG_W),
    .STATUS_COL(STATUS_COL), .SPARE_CMD(SPARE_CMD), .WB_CYCLES(WB_CYCLES)
  ) seq_i (
    .clk_i, .rst_ni, .start_i, .bus_done_i, .ready_i,
    .cmd_req_o, .addr_req_o, .rd_req_o, .bus_data_o,
    .clear_o(clear), .sample_o(sample), .blk_o(blk),
    .busy_o, .done_o
  );

  nand_zero_cnt #(.W(8), .ZW(ZW)) zc_i (
    .byte_i(bus_rdata_i), .zeros_o(zeros)
  );

  nand_bad_tally #(
    .BLK_W(BLK_W), .CNT_W(CNT_W), .ZW(ZW), .BAD_MIN(BAD_MIN)
  ) tally_i (
    .clk_i, .rst_ni, .clear_i(clear), .sample_i(sample),
    .blk_i(blk), .zeros_i(zeros),
    .valid_o(blk_valid_o), .idx_o(blk_idx_o), .bad_o(blk_bad_o),
    .cnt_o(bad_cnt_o)
  );
endmodule

// File: rtl/nand_badblk_scan_chk.sv
module nand_badblk_scan_chk #(
  parameter int NUM_BLOCKS = 512,
  parameter int BLK_W      = 9,
  parameter int CNT_W      = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             cmd_req_o,
  input logic             addr_req_o,
  input logic             rd_req_o,
  input logic             bus_done_i,
  input logic             ready_i,
  input logic             blk_valid_o,
  input logic [BLK_W-1:0] blk_idx_o,
  input logic             blk_bad_o,
  input logic [CNT_W-1:0] bad_cnt_o
);
  // R10
  one_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_req_o, addr_req_o, rd_req_o}));
  // R10
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(cmd_req_o || addr_req_o || rd_req_o));
  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !bus_done_i |=> rd_req_o);
  // R3
  rd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> ready_i);
  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |=> !blk_valid_o);
  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> bad_cnt_o == $past(bad_cnt_o) + CNT_W'(blk_bad_o));
  // R7
  done_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> blk_valid_o && blk_idx_o == BLK_W'(NUM_BLOCKS - 1));
  // R7
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
endmodule

bind nand_badblk_scan nand_badblk_scan_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .cmd_req_o(cmd_req_o), .addr_req_o(addr_req_o), .rd_req_o(rd_req_o),
  .bus_done_i(bus_done_i), .ready_i(ready_i), .blk_valid_o(blk_valid_o),
  .blk_idx_o(blk_idx_o), .blk_bad_o(blk_bad_o), .bad_cnt_o(bad_cnt_o)
);

// File: tb/nand_badblk_scan_tb_top.sv
module nand_badblk_scan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       busy_o, done_o, cmd_req_o, addr_req_o, rd_req_o;
  logic [7:0] bus_data_o;
  logic       bus_done_i = 1'b0;
  logic [7:0] bus_rdata_i = 8'h00;
  logic       ready_i = 1'b1;
  logic       blk_valid_o, blk_bad_o;
  logic [8:0] blk_idx_o;
  logic [9:0] bad_cnt_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  nand_badblk_scan dut_i (.*);

  int checks = 0, fails = 0;
  int scan_id = 0, phase = 0, cur_blk = 0, ref_cnt = 0, emitted = 0, dones = 0;
  int lat = 0, tgt = 1, txn = 0, busy_left = 0;
  int exp_idx_q = 0;
  bit exp_bad_q = 0, pend = 0, was_done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int zeros_of(logic [7:0] b);
    int z = 0;
    for (int i = 0; i < 8; i++) if (b[i] == 1'b0) z++;
    return z;
  endfunction

  function automatic logic [7:0] status_of(int sid, int b);
    if (sid == 0) begin
      case (b % 8)
        0: return 8'hFF;
        1: return 8'hFE;
        2: return 8'hFC;
        3: return 8'h00;
        4: return 8'h7F;
        5: return 8'hF7;
        6: return 8'hEE;
        default: return 8'h5A;
      endcase
    end
    if (b == 0 || b == NB - 1) return 8'h3F;
    if (b == 256) return 8'h01;
    if (b % 64 == 5) return 8'hDF;
    return 8'hFF;
  endfunction

  // flash bus model and reference comparison, all on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      int n_req;
      logic [7:0] sb;
      if (pend || blk_valid_o) begin
        chk(blk_valid_o == pend, "R5 verdict pulse timing", blk_valid_o, pend);
        if (pend && blk_valid_o) begin
          chk(blk_idx_o == exp_idx_q, "R5 block order", blk_idx_o, exp_idx_q);
          chk(blk_bad_o == exp_bad_q, "R4 verdict", blk_bad_o, exp_bad_q);
          chk(bad_cnt_o == ref_cnt, "R6 running count", bad_cnt_o, ref_cnt);
          emitted++;
        end
        pend = 0;
      end
      if (done_o) begin
        dones++;
        chk(emitted == NB && exp_idx_q == NB - 1, "R7 done with last block", emitted, NB);
      end
      if (was_done) chk(!busy_o && !done_o, "R7 single done then idle", {busy_o, done_o}, 0);
      was_done = done_o;
      n_req = int'(cmd_req_o) + int'(addr_req_o) + int'(rd_req_o);
      if (!busy_o && n_req != 0) chk(0, "R10 request while idle", n_req, 0);
      if (n_req > 1) chk(0, "R10 one request at a time", n_req, 1);
      if (rd_req_o && !ready_i) chk(0, "R3 read while device busy", 1, 0);

      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) ready_i = 1'b1;
      end

      if (bus_done_i) bus_done_i = 1'b0;
      else if (n_req == 1) begin
        lat++;
        if (lat >= tgt) begin
          lat = 0;
          txn++;
          tgt = 1 + (txn % 3);
          bus_done_i = 1'b1;
          case (phase)
            0: chk(cmd_req_o && bus_data_o == 8'h50, "R1 spare command", bus_data_o, 8'h50);
            1: chk(addr_req_o && bus_data_o == 8'd5, "R2 column byte", bus_data_o, 5);
            2: chk(addr_req_o && bus_data_o == ((cur_blk * 16) & 255), "R2 low row byte",
                   bus_data_o, (cur_blk * 16) & 255);
            3: begin
              chk(addr_req_o && bus_data_o == ((cur_blk * 16) >> 8), "R2 high row byte",
                  bus_data_o, (cur_blk * 16) >> 8);
              ready_i = 1'b0;
              busy_left = 2 + cur_blk % 5;
            end
            default: begin
              chk(rd_req_o, "R3 read request after address", rd_req_o, 1);
              sb = status_of(scan_id, cur_blk);
              bus_rdata_i = sb;
              exp_bad_q = (zeros_of(sb) >= 2);
              if (exp_bad_q) ref_cnt++;
              exp_idx_q = cur_blk;
              pend = 1;
              cur_blk++;
            end
          endcase
          phase = (phase + 1) % 5;
        end
      end
    end
  end

  task automatic run_scan(int sid, bit mid_start);
    bit timed_out = 1;
    scan_id = sid; phase = 0; cur_blk = 0; ref_cnt = 0; emitted = 0; dones = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 start accepted", busy_o, 1);
    chk(bad_cnt_o == 0, "R6 count cleared on start", bad_cnt_o, 0);
    if (mid_start) begin
      repeat (300) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      @(negedge clk_i);
      chk(busy_o == 1'b1 && cur_blk > 2, "R8 mid-scan start ignored", cur_blk, 3);
    end
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk_i);
      if (dones != 0) begin
        timed_out = 0;
        break;
      end
    end
    if (timed_out) chk(0, "R7 watchdog expired", dones, 1);
    repeat (3) @(negedge clk_i);
    chk(dones == 1, "R7 exactly one done", dones, 1);
    chk(emitted == NB, "R5 all blocks reported", emitted, NB);
    chk(bad_cnt_o == ref_cnt, "R6 count held after scan", bad_cnt_o, ref_cnt);
    chk(!busy_o, "R7 idle after scan", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !blk_valid_o, "R9 reset outputs",
        {busy_o, done_o, blk_valid_o}, 0);
    chk(!cmd_req_o && !addr_req_o && !rd_req_o, "R9 reset requests",
        {cmd_req_o, addr_req_o, rd_req_o}, 0);
    chk(bad_cnt_o == 0, "R9 reset count", bad_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_scan(0, 0);
    chk(ref_cnt == 256, "R4 scan A invalid total", bad_cnt_o, 256);
    repeat (5) @(negedge clk_i);
    run_scan(1, 1);
    chk(bad_cnt_o == 3, "R4 scan B invalid total", bad_cnt_o, 3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule